// File: doc/BRIEF.md
# Serial Peripheral Master with Command Prepend

This block is a serial peripheral (SPI) master that performs one complete transaction from on-chip byte buffers while a single chip-select line stays low. Software fills a transmit buffer over a small register bus. It then writes a message word that gives the byte total and the transfer kind. Finally it writes a command word with a start opcode, a prepend length and the target device number. The engine generates the serial clock and MOSI, and it drives the chosen chip select. It collects MISO bytes into a separate receive buffer and flags completion in a status bit. That bit can raise an interrupt through a mask.

Three transfer kinds exist. In full duplex every byte is both sent and captured. In write-only mode nothing is captured. Read-only mode may start with a prepend: up to 15 command bytes are sent and not captured, and then MOSI is held low while the remaining bytes are captured. Captured bytes always start at receive offset zero. Chip select drops at the start of a command and rises one half period after the final clock edge, so it cannot stay low from one command to the next.

Top module: `spi_cmd_master`

## Requirements
- R1: After reset all chip selects are high, SCLK is low, IRQ is low, and the message (0x00), status (0x03) and mask (0x04) registers read zero.
- R2: Clock-rate field value r (config 0x02 bits [2:0]) gives a half period of 2^min(r,6) system clocks, so r=6 and r=7 are both the slowest rate. Successive clock edges are one half period apart, and the first edge comes one half period after chip select falls.
- R3: CPOL (config bit 3) sets the idle SCLK level. With CPHA (config bit 4) at 0, data is sampled on leading edges and changed on trailing edges. With CPHA at 1 it is changed on leading edges and sampled on trailing edges. Bytes are 8 bits, MSB first.
- R4: Message type 0 (bits [15:14] of the message word 0x00, byte total in bits [5:0]) is full duplex: transmit byte i is sent from buffer address 0x40+i, and the byte received with it is stored at receive address 0x80+i.
- R5: Message type 2 is write only: all bytes are sent and the receive buffer is left unchanged.
- R6: Message type 1 is read only. With prepend count P (command bits [7:4]), bytes 0..P-1 are sent from the transmit buffer and not captured. After them MOSI is held low, and byte P+k is stored at receive offset k.
- R7: During a command only the line selected by command bits [9:8] is low. It falls on the clock after the start write and rises one half period after the last edge. At that point SCLK is back at its idle level.
- R8: Completion sets status bit 0. Writing the status register with bit 0 set clears it. IRQ equals status bit 0 ANDed with mask bit 0.
- R9: Status bit 1 reads 1 while a command runs. A command write made while busy is ignored and the running transfer is not disturbed.
- R10: A command write whose opcode (bits [3:0]) is not 3 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register and buffer address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 1 | Masked completion interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects, one per device |

## Verification
The bench runs all four clock modes, because a design that swaps the shift and sample edges for one CPHA value would capture bytes shifted by one bit. A read-only run with a three-byte prepend and the rest of the transmit buffer set to all ones catches an engine that keeps driving buffer data after the prepend or that stores the prepend bytes at receive offset zero. A second start issued in the middle of a transfer would move chip select to another device if it were not ignored. The slowest rate setting would give a wrong half period if the r=7 step were not clamped.

// File: rtl/spi_cmd_master.sv
module spi_cmd_master #(
  parameter int FIFO_DEPTH = 32,
  parameter int DEV_COUNT  = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int TYPE_SHIFT = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq,
  output logic                 sclk,
  output logic                 mosi,
  input  logic                 miso,
  output logic [DEV_COUNT-1:0] cs_n
);
  localparam int MAX_PRE  = 15;
  localparam int TX_DEPTH = FIFO_DEPTH + MAX_PRE;
  localparam int CNT_W    = $clog2(TX_DEPTH + 1);
  localparam int EC_W     = CNT_W + 4;
  localparam int IDX_W    = ADDR_W - 2;
  localparam int TX_AW    = $clog2(TX_DEPTH);
  localparam int RX_AW    = $clog2(FIFO_DEPTH);
  localparam int DEV_W    = DEV_COUNT > 1 ? $clog2(DEV_COUNT) : 1;
  localparam int RATE_TOP = 6;
  localparam int DIV_W    = RATE_TOP + 1;
  localparam logic [3:0] OP_START = 4'h3;
  localparam logic [1:0] T_FULL = 2'd0;
  localparam logic [1:0] T_READ = 2'd1;

  logic [7:0]       tx_mem [TX_DEPTH];
  logic [7:0]       rx_mem [FIFO_DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       type_q;
  logic [2:0]       rate_q;
  logic             cpol_q, cpha_q, mask_q, done_q, busy_q, ph_q;
  logic [3:0]       pre_q;
  logic [DEV_W-1:0] dev_q;
  logic [EC_W-1:0]  ec_q;
  logic [DIV_W-1:0] div_q;
  logic [6:0]       rsr_q;

  wire [1:0]       region = bus_addr[ADDR_W-1 -: 2];
  wire [IDX_W-1:0] idx    = bus_addr[IDX_W-1:0];
  wire reg_wr = bus_wr && region == 2'd0;
  wire cmd_wr = reg_wr && idx == IDX_W'(1);
  wire start  = cmd_wr && bus_wdata[3:0] == OP_START && !busy_q;
  wire clr_wr = reg_wr && idx == IDX_W'(3) && bus_wdata[0];

  wire [2:0]       rate_eff = rate_q > 3'(RATE_TOP) ? 3'(RATE_TOP) : rate_q;
  wire [DIV_W-1:0] half_m1  = (DIV_W'(1) << rate_eff) - DIV_W'(1);
  wire tick   = busy_q && div_q == '0;
  wire last   = ec_q == {cnt_q, 4'b0000};
  wire step   = tick && !last;
  wire finish = tick && last;
  wire samp   = step && (ec_q[0] == cpha_q);

  wire [CNT_W-1:0] pre_w   = CNT_W'(pre_q);
  wire [CNT_W-1:0] sbyte   = ec_q[EC_W-1:4];
  wire             capture = type_q == T_FULL || (type_q == T_READ && sbyte >= pre_w);
  wire [CNT_W-1:0] rx_at   = type_q == T_READ ? sbyte - pre_w : sbyte;
  wire rx_we = samp && ec_q[3:1] == 3'd7 && capture && rx_at < CNT_W'(FIFO_DEPTH);

  wire [EC_W-1:0]  ec_m1 = ec_q - EC_W'(1);
  wire [EC_W-2:0]  obit  = cpha_q ? (ec_q == '0 ? '0 : ec_m1[EC_W-1:1]) : ec_q[EC_W-1:1];
  wire [CNT_W-1:0] obyte = obit[EC_W-2:3];
  wire tx_on = obyte < cnt_q && obyte < CNT_W'(TX_DEPTH) &&
               !(type_q == T_READ && obyte >= pre_w);
  wire unused_bits = ^{bus_wdata, ec_m1[0]};

  assign mosi = busy_q && tx_on && tx_mem[obyte[TX_AW-1:0]][~obit[2:0]];
  assign sclk = ph_q ^ cpol_q;
  assign cs_n = busy_q ? ~(DEV_COUNT'(1) << dev_q) : '1;
  assign irq  = done_q & mask_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q  <= '0;
      type_q <= '0;
      rate_q <= '0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      mask_q <= 1'b0;
      done_q <= 1'b0;
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      pre_q  <= '0;
      dev_q  <= '0;
      ec_q   <= '0;
      div_q  <= '0;
      rsr_q  <= '0;
    end else begin
      if (reg_wr && idx == IDX_W'(0)) begin
        cnt_q  <= bus_wdata[CNT_W-1:0];
        type_q <= bus_wdata[TYPE_SHIFT +: 2];
      end
      if (reg_wr && idx == IDX_W'(2)) begin
        rate_q <= bus_wdata[2:0];
        cpol_q <= bus_wdata[3];
        cpha_q <= bus_wdata[4];
      end
      if (reg_wr && idx == IDX_W'(4)) mask_q <= bus_wdata[0];
      if (finish) done_q <= 1'b1;
      else if (clr_wr) done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        ec_q   <= '0;
        ph_q   <= 1'b0;
        div_q  <= half_m1;
        pre_q  <= bus_wdata[7:4];
        dev_q  <= bus_wdata[8 +: DEV_W];
      end else if (finish) begin
        busy_q <= 1'b0;
      end else if (step) begin
        ph_q  <= ~ph_q;
        ec_q  <= ec_q + EC_W'(1);
        div_q <= half_m1;
      end else if (busy_q) begin
        div_q <= div_q - DIV_W'(1);
      end
      if (samp) rsr_q <= {rsr_q[5:0], miso};
    end

  always_ff @(posedge clk) begin
    if (bus_wr && region == 2'd1 && idx < IDX_W'(TX_DEPTH))
      tx_mem[idx[TX_AW-1:0]] <= bus_wdata[7:0];
    if (rx_we)
      rx_mem[rx_at[RX_AW-1:0]] <= {rsr_q, miso};
  end

  always_comb begin
    bus_rdata = '0;
    case (region)
      2'd0:
        case (idx)
          IDX_W'(0): begin
            bus_rdata[CNT_W-1:0]        = cnt_q;
            bus_rdata[TYPE_SHIFT +: 2]  = type_q;
          end
          IDX_W'(2): bus_rdata[4:0] = {cpha_q, cpol_q, rate_q};
          IDX_W'(3): bus_rdata[1:0] = {busy_q, done_q};
          IDX_W'(4): bus_rdata[0]   = mask_q;
          default: ;
        endcase
      2'd1: if (idx < IDX_W'(TX_DEPTH)) bus_rdata[7:0] = tx_mem[idx[TX_AW-1:0]];
      2'd2: if (idx < IDX_W'(FIFO_DEPTH)) bus_rdata[7:0] = rx_mem[idx[RX_AW-1:0]];
      default: ;
    endcase
  end

  p_cs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) |-> $stable(cs_n));
  p_done_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> !busy_q && $past(busy_q));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && !finish |=> !done_q);
  p_sclk_rest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> sclk == cpol_q);
  p_bad_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !busy_q && bus_wdata[3:0] != OP_START |=> !busy_q);
endmodule

// File: tb/sim_spi_cmd_master.sv
module sim_spi_cmd_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq, sclk, mosi;
  logic miso = 1'b0;
  logic [3:0] cs_n;
  int checks = 0, fails = 0;

  spi_cmd_master u0 (.clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  always #4 clk = ~clk;

  bit m_act = 0, m_cpol = 0, m_cpha = 0, exp_done = 0, exp_mask = 0, chk_on = 0;
  int m_j = 0, m_h = 1, m_n = 0, m_dev = 0;
  logic [7:0] s_tx [64], s_rx [64], t_tx [64], prev [64];
  bit s_on = 0, s_prev = 0;
  int s_k = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wr = 1'b1; wdata = d;
    @(posedge clk);
    if (a == 8'h02) begin
      m_cpol = d[3]; m_cpha = d[4];
      m_h = 1 << ((d[2:0] > 3'd6) ? 6 : int'(d[2:0]));
    end
    if (a == 8'h04) exp_mask = d[0];
    if (a == 8'h03 && d[0]) exp_done = 0;
    if (a == 8'h01 && d[3:0] == 4'h3 && !m_act) begin
      m_act = 1; m_j = 0; m_dev = int'(d[9:8]);
    end
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic load(input int n, input int ktx, input int ks);
    for (int i = 0; i < n; i++) begin
      t_tx[i] = 8'(i * ktx + 7);
      s_tx[i] = 8'(i * ks + 150);
      wr_reg(8'(8'h40 + i), {8'h00, t_tx[i]});
    end
  endtask

  task automatic launch(input int n, input int typ, input int pre, input int dev, input bit hold);
    wr_reg(8'h00, 16'(typ << 14) | 16'(n));
    m_n = n;
    for (int i = 0; i < 64; i++) s_rx[i] = 8'hAA;
    wr_reg(8'h01, 16'(3 | (pre << 4) | (dev << 8)));
    if (hold) begin
      wait (!m_act);
      repeat (2) @(negedge clk);
    end
  endtask

  // cycle-by-cycle reference for chip select, serial clock and interrupt
  always @(negedge clk) if (chk_on) begin
    logic [3:0] ecs;
    logic esc;
    int e, endc;
    ecs = 4'hF;
    esc = m_cpol;
    if (m_act) begin
      endc = (16 * m_n + 1) * m_h;
      e = m_j / m_h;
      if (e > 16 * m_n) e = 16 * m_n;
      if (m_j < endc) begin
        ecs = ~(4'b0001 << m_dev);
        esc = m_cpol ^ e[0];
      end else begin
        exp_done = 1; m_act = 0;
      end
      m_j++;
    end
    check(cs_n == ecs, "R7 chip select", cs_n, ecs);
    check(sclk == esc, "R2 serial clock", sclk, esc);
    check(irq == (exp_done & exp_mask), "R8 irq", irq, exp_done & exp_mask);
  end

  // behavioural slave device
  always @(negedge clk) begin
    if (rst_n && cs_n[m_dev] == 1'b0) begin
      if (!s_on) begin
        s_on = 1; s_k = 0; s_prev = sclk;
        if (!m_cpha) miso = s_tx[0][7];
      end else if (sclk != s_prev) begin
        int b;
        b = s_k / 2;
        s_prev = sclk;
        if ((s_k % 2 == 0) != m_cpha) s_rx[b / 8][7 - b % 8] = mosi;
        else if (!m_cpha) begin
          b = b + 1;
          miso = s_tx[b / 8][7 - b % 8];
        end else miso = s_tx[b / 8][7 - b % 8];
        s_k++;
      end
    end else s_on = 0;
  end

  initial begin
    #(8 * 100000);
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    for (int i = 0; i < 64; i++) s_tx[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk_on = 1;
    // R1 reset state
    rd_reg(8'h03, v); check(v == 0, "R1 status", v, 0);
    rd_reg(8'h04, v); check(v == 0, "R1 mask", v, 0);
    rd_reg(8'h00, v); check(v == 0, "R1 message", v, 0);
    check(sclk == 0 && irq == 0 && cs_n == 4'hF, "R1 outputs", {sclk, irq, cs_n}, 6'h0F);

    // R3 R4 mode 0, fastest rate, device 1
    wr_reg(8'h02, 16'h0000);
    load(4, 53, 29);
    launch(4, 0, 0, 1, 1);
    for (int i = 0; i < 4; i++) begin
      check(s_rx[i] == t_tx[i], "R3 mosi mode0", s_rx[i], t_tx[i]);
      rd_reg(8'(8'h80 + i), v);
      check(v == 16'(s_tx[i]), "R4 rx store", v, s_tx[i]);
    end
    rd_reg(8'h03, v); check(v == 16'h1, "R8 done set", v, 1);
    wr_reg(8'h03, 16'hFFFF);
    rd_reg(8'h03, v); check(v == 16'h0, "R8 done clear", v, 0);

    // R2 R3 mode 3, rate 2, interrupt enabled
    wr_reg(8'h04, 16'h0001);
    wr_reg(8'h02, 16'h001A);
    load(3, 91, 47);
    launch(3, 0, 0, 0, 1);
    for (int i = 0; i < 3; i++) begin
      check(s_rx[i] == t_tx[i], "R3 mosi mode3", s_rx[i], t_tx[i]);
      rd_reg(8'(8'h80 + i), v);
      check(v == 16'(s_tx[i]), "R4 rx mode3", v, s_tx[i]);
      prev[i] = s_tx[i];
    end
    check(irq == 1'b1, "R8 irq raised", irq, 1);
    wr_reg(8'h03, 16'h0001);

    // R5 write only, mode 1, rate 1, device 2
    wr_reg(8'h02, 16'h0011);
    load(5, 13, 71);
    launch(5, 2, 0, 2, 1);
    for (int i = 0; i < 5; i++)
      check(s_rx[i] == t_tx[i], "R5 mosi write-only", s_rx[i], t_tx[i]);
    for (int i = 0; i < 3; i++) begin
      rd_reg(8'(8'h80 + i), v);
      check(v == 16'(prev[i]), "R5 rx untouched", v, prev[i]);
    end
    wr_reg(8'h03, 16'h0001);

    // R6 read only with prepend 3, mode 2, device 3
    wr_reg(8'h02, 16'h0008);
    load(8, 37, 19);
    for (int i = 3; i < 8; i++) wr_reg(8'(8'h40 + i), 16'h00FF);
    launch(8, 1, 3, 3, 1);
    for (int i = 0; i < 3; i++)
      check(s_rx[i] == t_tx[i], "R6 prepend sent", s_rx[i], t_tx[i]);
    for (int i = 3; i < 8; i++)
      check(s_rx[i] == 8'h00, "R6 mosi low after prepend", s_rx[i], 0);
    for (int i = 0; i < 5; i++) begin
      rd_reg(8'(8'h80 + i), v);
      check(v == 16'(s_tx[i + 3]), "R6 rx offset zero", v, s_tx[i + 3]);
    end
    wr_reg(8'h03, 16'h0001);

    // R9 command while busy
    wr_reg(8'h02, 16'h0003);
    load(2, 71, 83);
    launch(2, 0, 0, 0, 0);
    repeat (20) @(negedge clk);
    rd_reg(8'h03, v); check(v == 16'h2, "R9 busy flag", v, 2);
    wr_reg(8'h01, 16'h0203);
    wait (!m_act);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 2; i++)
      check(s_rx[i] == t_tx[i], "R9 transfer intact", s_rx[i], t_tx[i]);
    wr_reg(8'h03, 16'h0001);

    // R10 wrong opcode
    wr_reg(8'h01, 16'h0105);
    repeat (10) @(negedge clk);
    rd_reg(8'h03, v); check(v == 16'h0, "R10 no start", v, 0);

    // R2 rate 7 clamps to rate 6
    wr_reg(8'h02, 16'h0007);
    load(1, 1, 5);
    launch(1, 0, 0, 1, 1);
    check(s_rx[0] == t_tx[0], "R2 slowest rate data", s_rx[0], t_tx[0]);
    wr_reg(8'h03, 16'h0001);

    // R8 mask gating
    wr_reg(8'h04, 16'h0000);
    wr_reg(8'h02, 16'h0000);
    load(1, 3, 9);
    launch(1, 0, 0, 0, 1);
    rd_reg(8'h03, v); check(v == 16'h1, "R8 done masked", v, 1);
    check(irq == 1'b0, "R8 irq masked", irq, 0);
    wr_reg(8'h04, 16'h0001);
    @(negedge clk); #1 check(irq == 1'b1, "R8 irq unmasked", irq, 1);
    wr_reg(8'h03, 16'h0001);
    @(negedge clk); #1 check(irq == 1'b0, "R8 irq cleared", irq, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule